// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block finishes the job of a Reed-Solomon decoder working on 512-byte data blocks. The decoder reports up to four corrections. Each correction is a 1-based index of a 9-bit symbol and a 9-bit error mask. The symbols are packed across byte boundaries, so the block turns each index into a byte offset and a bit shift. It then flips the masked bits in the buffer holding the data, one byte at a time, by read-modify-write.

A report is accepted with a single-cycle start strobe. The block copies the count, the flag for an uncorrectable condition and all four index/mask entries into its own registers. It then walks the valid entries from the highest down to entry 0. A correction may touch one byte or two adjacent bytes. Corrections that land outside the block are skipped. When the report is marked uncorrectable, or its count is out of range, no data is touched and completion is signalled at once. A single-cycle done pulse ends every report, and the uncorrectable flag is passed out alongside it.

The buffer is reached through a plain byte port. A read strobe returns data on the following cycle.

Top module: `rs_fix_applier`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done_o`, `buf_rd_o` and `buf_wr_o` are low.
- R2: For an entry with index `n` (n ≥ 1), let `d = n - 1`. The byte offset is `d + (d >> 3)` and the shift is `d & 7`. The low 8 bits of `mask << shift` are XORed into the byte at that offset. Bits 15:8 are XORed into the byte at offset + 1.
- R3: A correction whose byte offset is 512 or more changes no byte. A correction whose offset is exactly 511 changes only byte 511. An entry with index 0 changes no byte.
- R4: A count N from 1 to 4 applies entries N-1 down to 0, in that order. Entries N and above are not applied. Entry k sits in `err_idx_i[k*10 +: 10]` and `err_mask_i[k*9 +: 9]`.
- R5: When `uncorr_i` is high at start, no byte is read or written. `done_o` and `uncorr_o` are both high in the cycle after start.
- R6: A count of 0, or a count above 4, changes no byte, and `done_o` is high in the cycle after start.
- R7: Each entry takes one evaluation cycle plus two cycles per byte it changes (a read cycle, then a write cycle). `done_o` is a single-cycle pulse that arrives 1 + Σ(entry cycles) cycles after start.
- R8: A start strobe that arrives while a report is in progress is ignored.
- R9: Every write goes to the address read in the previous cycle, and every read is followed directly by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that accepts a correction report |
| err_cnt_i | input | 3 | Number of corrections reported |
| uncorr_i | input | 1 | The decoder found the block uncorrectable |
| err_idx_i | input | 40 | Four 10-bit 1-based symbol indices |
| err_mask_i | input | 36 | Four 9-bit error masks |
| buf_addr_o | output | 9 | Byte address into the data buffer |
| buf_rd_o | output | 1 | Buffer read strobe; data is returned on the next cycle |
| buf_rdata_i | input | 8 | Byte read from the buffer |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Corrected byte to write |
| done_o | output | 1 | Single-cycle pulse when the report is finished |
| uncorr_o | output | 1 | Uncorrectable flag, shown together with `done_o` |

## Verification
A wrong entry pointer or a wrong byte phase shows up in the buffer contents, and in the address of the first write of a report. The bench compares both against a model built only from the requirements. A wrong state sequence moves the done pulse away from the cycle the model predicts, so the fault is caught within the same report. A report accepted twice flips the same bits back to their original values, which the buffer comparison exposes.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_RD,
    S_WR,
    S_DONE
  } fix_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/rs_fix_pick.sv
module rs_fix_pick #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 10,
  parameter int SYM_W   = 9,
  localparam int PTR_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT*IDX_W-1:0] idx_flat,
  input  logic [NUM_ENT*SYM_W-1:0] mask_flat,
  input  logic [PTR_W-1:0]         sel,
  output logic [IDX_W-1:0]         idx,
  output logic [SYM_W-1:0]         mask
);

  logic [IDX_W-1:0] idx_arr  [NUM_ENT];
  logic [SYM_W-1:0] mask_arr [NUM_ENT];

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    assign idx_arr[k]  = idx_flat[k*IDX_W +: IDX_W];
    assign mask_arr[k] = mask_flat[k*SYM_W +: SYM_W];
  end

  assign idx  = idx_arr[sel];
  assign mask = mask_arr[sel];

endmodule

// File: rtl/rs_fix_locate.sv
module rs_fix_locate #(
  parameter int IDX_W       = 10,
  parameter int SYM_W       = 9,
  parameter int BLOCK_BYTES = 512,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int OFF_W      = IDX_W + 1,
  localparam int SPAN_W     = 16
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [SYM_W-1:0]  mask,
  output logic [ADDR_W-1:0] off,
  output logic [7:0]        lo,
  output logic [7:0]        hi,
  output logic              hit,
  output logic              two
);

  logic [IDX_W-1:0]  pos;
  logic [OFF_W-1:0]  off_full;
  logic [SPAN_W-1:0] span;

  // zero-based symbol position; symbols are 9 bits, so each group of
  // eight symbols spills one extra byte
  assign pos      = idx - IDX_W'(1);
  assign off_full = OFF_W'(pos) + OFF_W'(pos >> 3);
  assign span     = SPAN_W'(mask) << pos[2:0];

  assign off = off_full[ADDR_W-1:0];
  assign lo  = span[7:0];
  assign hi  = span[15:8];
  assign hit = (idx != '0) && (off_full < OFF_W'(BLOCK_BYTES));
  assign two = off_full < OFF_W'(BLOCK_BYTES - 1);

endmodule

// File: rtl/rs_fix_applier.sv
module rs_fix_applier
  import rs_fix_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int IDX_W       = 10,
  parameter int SYM_W       = 9,
  parameter int MAX_ERR     = 4,
  parameter int CNT_W       = 3,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int PTR_W      = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         err_cnt_i,
  input  logic                     uncorr_i,
  input  logic [MAX_ERR*IDX_W-1:0] err_idx_i,
  input  logic [MAX_ERR*SYM_W-1:0] err_mask_i,
  output logic [ADDR_W-1:0]        buf_addr_o,
  output logic                     buf_rd_o,
  input  logic [7:0]               buf_rdata_i,
  output logic                     buf_wr_o,
  output logic [7:0]               buf_wdata_o,
  output logic                     done_o,
  output logic                     uncorr_o
);

  fix_state_e               st_q, st_d;
  logic [PTR_W-1:0]         ptr_q, ptr_d;
  logic                     hi_phase_q, hi_phase_d;
  logic [MAX_ERR*IDX_W-1:0] idx_q;
  logic [MAX_ERR*SYM_W-1:0] mask_q;
  logic                     uncorr_q;
  logic [ADDR_W-1:0]        off_q;
  logic [7:0]               lo_q, hi_q;
  logic                     two_q;

  logic                     cap_en, loc_en;
  logic                     skip_rpt;
  logic                     last_ent;
  logic                     idle_w;

  logic [IDX_W-1:0]         cur_idx;
  logic [SYM_W-1:0]         cur_mask;
  logic [ADDR_W-1:0]        loc_off;
  logic [7:0]               loc_lo, loc_hi;
  logic                     loc_hit, loc_two;

  rs_fix_pick #(
    .NUM_ENT(MAX_ERR),
    .IDX_W  (IDX_W),
    .SYM_W  (SYM_W)
  ) u_pick (
    .idx_flat (idx_q),
    .mask_flat(mask_q),
    .sel      (ptr_q),
    .idx      (cur_idx),
    .mask     (cur_mask)
  );

  rs_fix_locate #(
    .IDX_W      (IDX_W),
    .SYM_W      (SYM_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_locate (
    .idx (cur_idx),
    .mask(cur_mask),
    .off (loc_off),
    .lo  (loc_lo),
    .hi  (loc_hi),
    .hit (loc_hit),
    .two (loc_two)
  );

  assign idle_w   = (st_q == S_IDLE);
  assign last_ent = (ptr_q == '0);
  assign skip_rpt = uncorr_i || (err_cnt_i == '0) ||
                    (err_cnt_i > CNT_W'(MAX_ERR));

  // next-state logic
  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    hi_phase_d = hi_phase_q;
    cap_en     = 1'b0;
    loc_en     = 1'b0;
    buf_rd_o   = 1'b0;
    buf_wr_o   = 1'b0;
    done_o     = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          if (skip_rpt) begin
            st_d = S_DONE;
          end else begin
            ptr_d = PTR_W'(err_cnt_i - CNT_W'(1));
            st_d  = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        if (loc_hit) begin
          loc_en     = 1'b1;
          hi_phase_d = 1'b0;
          st_d       = S_RD;
        end else if (last_ent) begin
          st_d = S_DONE;
        end else begin
          ptr_d = ptr_q - PTR_W'(1);
          st_d  = S_LOAD;
        end
      end
      S_RD: begin
        buf_rd_o = 1'b1;
        st_d     = S_WR;
      end
      S_WR: begin
        buf_wr_o = 1'b1;
        if (!hi_phase_q && two_q) begin
          hi_phase_d = 1'b1;
          st_d       = S_RD;
        end else if (last_ent) begin
          st_d = S_DONE;
        end else begin
          ptr_d = ptr_q - PTR_W'(1);
          st_d  = S_LOAD;
        end
      end
      S_DONE: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign buf_addr_o  = hi_phase_q ? (off_q + ADDR_W'(1)) : off_q;
  assign buf_wdata_o = buf_rdata_i ^ (hi_phase_q ? hi_q : lo_q);
  assign uncorr_o    = done_o && uncorr_q;

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      ptr_q      <= '0;
      hi_phase_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      hi_phase_q <= hi_phase_d;
    end
  end

  // report capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      mask_q   <= '0;
      uncorr_q <= 1'b0;
    end else if (cap_en) begin
      idx_q    <= err_idx_i;
      mask_q   <= err_mask_i;
      uncorr_q <= uncorr_i;
    end
  end

  // located correction, enabled when an entry hits the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      two_q <= 1'b0;
    end else if (loc_en) begin
      off_q <= loc_off;
      lo_q  <= loc_lo;
      hi_q  <= loc_hi;
      two_q <= loc_two;
    end
  end

endmodule

// File: rtl/rs_fix_applier_chk.sv
module rs_fix_applier_chk #(
  parameter int ADDR_W  = 9,
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CNT_W-1:0]  err_cnt_i,
  input logic              uncorr_i,
  input logic              idle,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              buf_rd_o,
  input logic              buf_wr_o,
  input logic              done_o,
  input logic              uncorr_o
);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_o |-> ($past(buf_rd_o) && buf_addr_o == $past(buf_addr_o))); // R9

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |=> buf_wr_o); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_UNCORR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && uncorr_i) |=> (done_o && uncorr_o && !buf_rd_o && !buf_wr_o)); // R5

  AST_BAD_COUNT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && (err_cnt_i == '0 || err_cnt_i > CNT_W'(MAX_ERR)))
      |=> (done_o && !buf_rd_o && !buf_wr_o)); // R6

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!buf_rd_o && !buf_wr_o && !done_o)); // R1

endmodule

bind rs_fix_applier rs_fix_applier_chk #(
  .ADDR_W (ADDR_W),
  .MAX_ERR(MAX_ERR),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .err_cnt_i (err_cnt_i),
  .uncorr_i  (uncorr_i),
  .idle      (idle_w),
  .buf_addr_o(buf_addr_o),
  .buf_rd_o  (buf_rd_o),
  .buf_wr_o  (buf_wr_o),
  .done_o    (done_o),
  .uncorr_o  (uncorr_o)
);

// File: tb/rs_fix_applier_tb_top.sv
`timescale 1ns/1ps
module rs_fix_applier_tb_top;

  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cnt = '0;
  logic        unc = 1'b0;
  logic [39:0] idx_f = '0;
  logic [35:0] mask_f = '0;
  logic [8:0]  addr;
  logic        rd, wr, done, unc_o;
  logic [7:0]  rdata = '0;
  logic [7:0]  wdata;

  int tests = 0;
  int fails = 0;
  int first_wr = -1;

  logic [7:0] mem  [NB];
  logic [7:0] expm [NB];

  always #10 clk = ~clk;

  rs_fix_applier dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .err_cnt_i  (cnt),
    .uncorr_i   (unc),
    .err_idx_i  (idx_f),
    .err_mask_i (mask_f),
    .buf_addr_o (addr),
    .buf_rd_o   (rd),
    .buf_rdata_i(rdata),
    .buf_wr_o   (wr),
    .buf_wdata_o(wdata),
    .done_o     (done),
    .uncorr_o   (unc_o)
  );

  // buffer model with one cycle of read latency
  always @(posedge clk) begin
    if (rd) rdata <= mem[addr];
    if (wr) begin
      mem[addr] <= wdata;
      if (first_wr < 0) first_wr = int'(addr);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // one report: expected buffer, latency and first write come from R2..R7
  task automatic run_case(input int n, input bit u, input int i0, input int i1,
                          input int i2, input int i3, input int m0, input int m1,
                          input int m2, input int m3, input int hold, input string req);
    int ix[4];
    int mk[4];
    int lat;
    int exp_first;
    int mism;
    int bad_at;
    ix = '{i0, i1, i2, i3};
    mk = '{m0, m1, m2, m3};
    for (int b = 0; b < NB; b++) expm[b] = mem[b];
    lat = 1;
    exp_first = -1;
    if (!u && n >= 1 && n <= 4) begin
      for (int j = n - 1; j >= 0; j--) begin
        int d, off, sm, nb;
        lat += 1;
        if (ix[j] == 0) continue;
        d   = ix[j] - 1;
        off = d + (d / 8);
        if (off >= NB) continue;
        sm  = mk[j] << (d % 8);
        nb  = (off < NB - 1) ? 2 : 1;
        expm[off] ^= 8'(sm);
        if (nb == 2) expm[off + 1] ^= 8'(sm >> 8);
        if (exp_first < 0) exp_first = off;
        lat += 2 * nb;
      end
    end
    first_wr = -1;
    cnt    = 3'(n);
    unc    = u;
    idx_f  = {10'(i3), 10'(i2), 10'(i1), 10'(i0)};
    mask_f = {9'(m3), 9'(m2), 9'(m1), 9'(m0)};
    start  = 1'b1;
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k >= hold) start = 1'b0;
      check(done == (k == lat), {req, " done timing (R7)"}, int'(done), int'(k == lat));
      if (k == lat) check(unc_o == u, {req, " uncorr flag"}, int'(unc_o), int'(u));
    end
    mism = 0;
    bad_at = 0;
    for (int b = 0; b < NB; b++)
      if (mem[b] !== expm[b]) begin
        if (mism == 0) bad_at = b;
        mism++;
      end
    check(mism == 0, {req, " buffer contents"}, int'(mem[bad_at]), int'(expm[bad_at]));
    check(first_wr == exp_first, {req, " first write address"}, first_wr, exp_first);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) mem[b] = 8'(b * 7 + 3);
    repeat (3) @(negedge clk);
    check(!done && !rd && !wr, "R1 outputs in reset", int'({done, rd, wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !rd && !wr, "R1 outputs after reset", int'({done, rd, wr}), 0);

    // R2: first symbol, aligned; eighth symbol, shift 7 straddling
    run_case(1, 0, 1, 0, 0, 0, 'h1FF, 0, 0, 0, 1, "R2 idx1");
    run_case(1, 0, 8, 0, 0, 0, 'h1FF, 0, 0, 0, 1, "R2 idx8");
    // R4: four entries applied from entry 3 down
    run_case(4, 0, 20, 100, 300, 3, 'h0A5, 'h1C3, 'h001, 'h100, 1, "R4 four entries");
    // R3: offset 511 touches one byte, offset 513 ignored
    run_case(2, 0, 457, 456, 0, 0, 'h1FF, 'h1FF, 0, 0, 1, "R3 block edge");
    // R3: index 0 and far index ignored, middle one applied
    run_case(3, 0, 600, 50, 0, 0, 'h001, 'h007, 'h1FF, 0, 1, "R3 idx zero");
    // R4: count 2 leaves entries 2 and 3 alone
    run_case(2, 0, 200, 33, 77, 88, 'h011, 'h0F0, 'h1FF, 'h1FF, 1, "R4 count two");
    // R5: uncorrectable report
    run_case(2, 1, 10, 11, 0, 0, 'h1FF, 'h1FF, 0, 0, 1, "R5 uncorrectable");
    // R6: count 0 and counts above 4
    run_case(0, 0, 10, 11, 12, 13, 'h1FF, 'h1FF, 'h1FF, 'h1FF, 1, "R6 count zero");
    run_case(5, 0, 10, 11, 12, 13, 'h1FF, 'h1FF, 'h1FF, 'h1FF, 1, "R6 count five");
    run_case(7, 0, 10, 11, 12, 13, 'h1FF, 'h1FF, 'h1FF, 'h1FF, 1, "R6 count seven");
    // R8: start held for three cycles must be taken once
    run_case(1, 0, 1, 0, 0, 0, 'h055, 0, 0, 0, 3, "R8 start while busy");
    // R2: same byte hit twice by different entries
    run_case(2, 0, 9, 9, 0, 0, 'h003, 'h081, 0, 0, 1, "R2 overlap");

    summary();
    $finish;
  end

endmodule